// File: doc/BRIEF.md
# Four-Channel Memory Copy Engine

This block moves blocks of memory from one place to another on behalf of a processor. Software programs each of four channels through a 32-bit register port. Each channel holds a source address, a destination address, an element count and a control word, plus a pair of descriptor-address words that are kept but not acted on. Writing a channel's control word with its enable bit set queues a copy. A single mover then carries the copy out one element at a time over a memory master port. That port has a read request channel, a read response channel and a write channel, each with a valid/ready handshake.

Each element is 1, 2, 4 or 8 bytes wide. The element sits in the low bytes of the 64-bit data bus in little-endian order, and every byte lane above the element width is zero on the write channel. The source address and the destination address each step by the element width after every element, and each step can be switched off separately. A fixed address therefore gives gather-to-one or fill-from-one behaviour. When a copy ends, the channel's bit in the shared completion register is set and the channel's enable bit is cleared. Software clears completion bits by writing ones to them.

Back-pressure: the read request and the write request keep valid, address, size and data steady until ready is seen. The engine raises read-response ready only while it waits for a response, and it accepts the response in the cycle in which valid and ready are both high. It issues no new read before the previous element's write has been accepted.

Top module: `chan_copy_dma`

## Requirements
- R1: After reset, every channel register and the completion register read as zero.
- R2: Channel c owns register offsets 8c to 8c+7, holding in order: control, count, source high, source low, destination high, destination low, descriptor high, descriptor low. Every one of them reads back the last value written. A transfer's first read address is {source high, source low}.
- R3: A write to the high word of a 64-bit address leaves its low word unchanged, and a write to the low word leaves the high word unchanged.
- R4: A control write with bit 31 set queues a copy of count[15:0] elements, and count bits 31:16 are ignored. When count[15:0] is zero, no memory request is made and no completion bit is set.
- R5: Control bits 26:25 give the element size code z. An element is 2^z bytes, both size outputs carry z, and write data bytes at or above 2^z are zero.
- R6: Control bit 23 enables the source address step and bit 24 enables the destination address step. An enabled address grows by 2^z after every element, and a disabled one stays fixed. The result in memory equals an element-by-element in-order copy.
- R7: Each element is one accepted read request, then one accepted response, then one accepted write. No read request is accepted between a read and its write.
- R8: While a request's valid is high and ready is low, valid, address, size and write data stay unchanged in the next cycle.
- R9: When a channel's last write is accepted, bit c of the completion register (offset 0x20) becomes 1 and bit 31 of that channel's control register becomes 0. The other control bits are kept.
- R10: Writing the completion register clears exactly the bits that are 1 in the written value, and leaves the others unchanged.
- R11: Queued channels wait while a copy runs and are then served one at a time, the lowest channel number first.
- R12: Offsets above 0x20 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, same cycle |
| mrd_req_valid | output | 1 | Read request valid |
| mrd_req_ready | input | 1 | Read request accepted |
| mrd_addr | output | MADDR_W | Read byte address |
| mrd_size | output | 2 | Read size code, 2^code bytes |
| mrd_rsp_valid | input | 1 | Read response valid |
| mrd_rsp_ready | output | 1 | Engine waiting for a read response |
| mrd_rsp_data | input | MDATA_W | Read data, element in the low bytes |
| mwr_valid | output | 1 | Write request valid |
| mwr_ready | input | 1 | Write request accepted |
| mwr_addr | output | MADDR_W | Write byte address |
| mwr_size | output | 2 | Write size code |
| mwr_data | output | MDATA_W | Write data, upper lanes zero |

## Verification
A register read is combinational, so it is due in the same cycle. The bench samples it 1 ns after the falling edge that set the offset, and a register write is seen by the read that follows. Read requests become valid two rising edges after the control write. The completion bit follows the last accepted write by two edges. The bench therefore polls the completion register once per cycle, with a bound, instead of counting to a fixed edge. The memory responder decides ready on the falling edge and counts a handshake when valid and ready are both high there. It answers a read one cycle later, and it checks holding and ordering against the next falling edge.

// File: rtl/ccd_pkg.sv
package ccd_pkg;
  // register slots inside one channel window; the order is decoded by software
  localparam int unsigned SLOT_W   = 3;
  localparam int unsigned W_CTRL   = 0;
  localparam int unsigned W_CNT    = 1;
  localparam int unsigned W_SRC_HI = 2;
  localparam int unsigned W_SRC_LO = 3;
  localparam int unsigned W_DST_HI = 4;
  localparam int unsigned W_DST_LO = 5;

  // control word fields
  localparam int unsigned B_EN   = 31;
  localparam int unsigned B_SZ   = 25;
  localparam int unsigned B_DINC = 24;
  localparam int unsigned B_SINC = 23;

  typedef enum logic [2:0] {
    MV_IDLE,
    MV_RREQ,
    MV_RWAIT,
    MV_WREQ,
    MV_FIN
  } mv_state_e;
endpackage

// File: rtl/ccd_pick.sv
module ccd_pick #(
  parameter int unsigned NCH = 4,
  localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req_i,
  output logic           any_o,
  output logic [CW-1:0]  idx_o
);
  logic [NCH:0]   blk;
  logic [NCH-1:0] gnt;

  assign blk[0] = 1'b0;
  for (genvar i = 0; i < NCH; i++) begin : g_chain
    assign gnt[i]   = req_i[i] & ~blk[i];
    assign blk[i+1] = blk[i] | req_i[i];
  end

  assign any_o = blk[NCH];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NCH; i++) begin
      if (gnt[i]) idx_o = CW'(i);
    end
  end

  // R11
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R11
  lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> ((req_i & ((NCH'(1) << idx_o) - NCH'(1))) == '0));
endmodule

// File: rtl/ccd_regs.sv
module ccd_regs import ccd_pkg::*; #(
  parameter int unsigned NCH     = 4,
  parameter int unsigned REG_AW  = 6,
  parameter int unsigned REG_DW  = 32,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned MADDR_W = 64,
  localparam int unsigned CW       = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int unsigned STAT_OFF = NCH * 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [REG_DW-1:0]  reg_wdata,
  output logic [REG_DW-1:0]  reg_rdata,
  output logic [NCH-1:0]     pend_o,
  input  logic               take_i,
  input  logic [CW-1:0]      take_ch_i,
  input  logic               fin_i,
  input  logic [CW-1:0]      fin_ch_i,
  output logic [MADDR_W-1:0] job_src_o,
  output logic [MADDR_W-1:0] job_dst_o,
  output logic [CNT_W-1:0]   job_cnt_o,
  output logic [1:0]         job_sz_o,
  output logic               job_sinc_o,
  output logic               job_dinc_o
);
  logic [REG_DW-1:0] regs_q [NCH][8];
  logic [NCH-1:0]    pend_q;
  logic [NCH-1:0]    done_q;

  logic              in_ch;
  logic              at_stat;
  logic [CW-1:0]     hit_idx;
  logic [SLOT_W-1:0] slot;

  assign in_ch   = (reg_addr < REG_AW'(STAT_OFF));
  assign at_stat = (reg_addr == REG_AW'(STAT_OFF));
  assign hit_idx = reg_addr[SLOT_W+CW-1:SLOT_W];
  assign slot    = reg_addr[SLOT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++)
        for (int k = 0; k < 8; k++) regs_q[c][k] <= '0;
      pend_q <= '0;
      done_q <= '0;
    end else begin
      if (reg_we && at_stat) done_q <= done_q & ~reg_wdata[NCH-1:0];
      for (int c = 0; c < NCH; c++) begin
        if (fin_i && fin_ch_i == CW'(c)) begin
          done_q[c] <= 1'b1;
          regs_q[c][W_CTRL][B_EN] <= 1'b0;
        end
        if (take_i && take_ch_i == CW'(c)) pend_q[c] <= 1'b0;
      end
      if (reg_we && in_ch) begin
        regs_q[hit_idx][slot] <= reg_wdata;
        if (slot == SLOT_W'(W_CTRL) && reg_wdata[B_EN] &&
            regs_q[hit_idx][W_CNT][CNT_W-1:0] != '0)
          pend_q[hit_idx] <= 1'b1;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (in_ch)        reg_rdata = regs_q[hit_idx][slot];
    else if (at_stat) reg_rdata = {{(REG_DW-NCH){1'b0}}, done_q};
  end

  assign pend_o     = pend_q;
  assign job_src_o  = {regs_q[take_ch_i][W_SRC_HI], regs_q[take_ch_i][W_SRC_LO]};
  assign job_dst_o  = {regs_q[take_ch_i][W_DST_HI], regs_q[take_ch_i][W_DST_LO]};
  assign job_cnt_o  = regs_q[take_ch_i][W_CNT][CNT_W-1:0];
  assign job_sz_o   = regs_q[take_ch_i][W_CTRL][B_SZ+1:B_SZ];
  assign job_sinc_o = regs_q[take_ch_i][W_CTRL][B_SINC];
  assign job_dinc_o = regs_q[take_ch_i][W_CTRL][B_DINC];

  // R11
  take_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |-> pend_q[take_ch_i]);

  // R9
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_i |=> done_q[$past(fin_ch_i)]);
endmodule

// File: rtl/ccd_mover.sv
module ccd_mover import ccd_pkg::*; #(
  parameter int unsigned NCH     = 4,
  parameter int unsigned MADDR_W = 64,
  parameter int unsigned MDATA_W = 64,
  parameter int unsigned CNT_W   = 16,
  localparam int unsigned CW    = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int unsigned LANES = MDATA_W / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               any_i,
  input  logic [CW-1:0]      pick_i,
  output logic               take_o,
  input  logic [MADDR_W-1:0] job_src_i,
  input  logic [MADDR_W-1:0] job_dst_i,
  input  logic [CNT_W-1:0]   job_cnt_i,
  input  logic [1:0]         job_sz_i,
  input  logic               job_sinc_i,
  input  logic               job_dinc_i,
  output logic               fin_o,
  output logic [CW-1:0]      fin_ch_o,
  output logic               mrd_req_valid,
  input  logic               mrd_req_ready,
  output logic [MADDR_W-1:0] mrd_addr,
  output logic [1:0]         mrd_size,
  input  logic               mrd_rsp_valid,
  output logic               mrd_rsp_ready,
  input  logic [MDATA_W-1:0] mrd_rsp_data,
  output logic               mwr_valid,
  input  logic               mwr_ready,
  output logic [MADDR_W-1:0] mwr_addr,
  output logic [1:0]         mwr_size,
  output logic [MDATA_W-1:0] mwr_data
);
  mv_state_e          state_q;
  logic [CW-1:0]      cur_ch_q;
  logic [MADDR_W-1:0] src_q, dst_q, step;
  logic [CNT_W-1:0]   left_q;
  logic [1:0]         sz_q;
  logic               sinc_q, dinc_q;
  logic [MDATA_W-1:0] buf_q, rsp_masked;

  assign step = MADDR_W'(4'd1 << sz_q);

  always_comb begin
    for (int b = 0; b < LANES; b++)
      rsp_masked[b*8 +: 8] = (32'(b) < (32'd1 << sz_q)) ? mrd_rsp_data[b*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= MV_IDLE;
      cur_ch_q <= '0;
      src_q    <= '0;
      dst_q    <= '0;
      left_q   <= '0;
      sz_q     <= '0;
      sinc_q   <= 1'b0;
      dinc_q   <= 1'b0;
      buf_q    <= '0;
    end else begin
      case (state_q)
        MV_IDLE: if (any_i) begin
          cur_ch_q <= pick_i;
          src_q    <= job_src_i;
          dst_q    <= job_dst_i;
          left_q   <= job_cnt_i;
          sz_q     <= job_sz_i;
          sinc_q   <= job_sinc_i;
          dinc_q   <= job_dinc_i;
          state_q  <= MV_RREQ;
        end
        MV_RREQ: if (mrd_req_ready) state_q <= MV_RWAIT;
        MV_RWAIT: if (mrd_rsp_valid) begin
          buf_q   <= rsp_masked;
          state_q <= MV_WREQ;
        end
        MV_WREQ: if (mwr_ready) begin
          if (sinc_q) src_q <= src_q + step;
          if (dinc_q) dst_q <= dst_q + step;
          left_q  <= left_q - CNT_W'(1);
          state_q <= (left_q == CNT_W'(1)) ? MV_FIN : MV_RREQ;
        end
        MV_FIN:  state_q <= MV_IDLE;
        default: state_q <= MV_IDLE;
      endcase
    end
  end

  assign take_o        = (state_q == MV_IDLE) && any_i;
  assign fin_o         = (state_q == MV_FIN);
  assign fin_ch_o      = cur_ch_q;
  assign mrd_req_valid = (state_q == MV_RREQ);
  assign mrd_addr      = src_q;
  assign mrd_size      = sz_q;
  assign mrd_rsp_ready = (state_q == MV_RWAIT);
  assign mwr_valid     = (state_q == MV_WREQ);
  assign mwr_addr      = dst_q;
  assign mwr_size      = sz_q;
  assign mwr_data      = buf_q;

  // R8
  rreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mrd_req_valid && !mrd_req_ready) |=>
      (mrd_req_valid && $stable(mrd_addr) && $stable(mrd_size)));

  // R8
  wreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mwr_valid && !mwr_ready) |=>
      (mwr_valid && $stable(mwr_addr) && $stable(mwr_data) && $stable(mwr_size)));

  // R7
  rsp_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mrd_rsp_valid && mrd_rsp_ready) |=> (mwr_valid && !mrd_req_valid));

  // R5
  upper_lanes_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mwr_valid |-> ((mwr_data >> (32'd8 << mwr_size)) == '0));

  // R4
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (job_cnt_i != '0));
endmodule

// File: rtl/chan_copy_dma.sv
module chan_copy_dma #(
  parameter int unsigned NCH     = 4,
  parameter int unsigned REG_AW  = 6,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned MADDR_W = 64,
  parameter int unsigned MDATA_W = 64,
  localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               mrd_req_valid,
  input  logic               mrd_req_ready,
  output logic [MADDR_W-1:0] mrd_addr,
  output logic [1:0]         mrd_size,
  input  logic               mrd_rsp_valid,
  output logic               mrd_rsp_ready,
  input  logic [MDATA_W-1:0] mrd_rsp_data,
  output logic               mwr_valid,
  input  logic               mwr_ready,
  output logic [MADDR_W-1:0] mwr_addr,
  output logic [1:0]         mwr_size,
  output logic [MDATA_W-1:0] mwr_data
);
  logic [NCH-1:0]     pend;
  logic               any, take, fin;
  logic [CW-1:0]      pick, fin_ch;
  logic [MADDR_W-1:0] job_src, job_dst;
  logic [CNT_W-1:0]   job_cnt;
  logic [1:0]         job_sz;
  logic               job_sinc, job_dinc;

  ccd_regs #(
    .NCH(NCH), .REG_AW(REG_AW), .REG_DW(32), .CNT_W(CNT_W), .MADDR_W(MADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pend_o(pend), .take_i(take), .take_ch_i(pick),
    .fin_i(fin), .fin_ch_i(fin_ch),
    .job_src_o(job_src), .job_dst_o(job_dst), .job_cnt_o(job_cnt),
    .job_sz_o(job_sz), .job_sinc_o(job_sinc), .job_dinc_o(job_dinc)
  );

  ccd_pick #(.NCH(NCH)) u_pick (
    .clk(clk), .rst_n(rst_n), .req_i(pend), .any_o(any), .idx_o(pick)
  );

  ccd_mover #(
    .NCH(NCH), .MADDR_W(MADDR_W), .MDATA_W(MDATA_W), .CNT_W(CNT_W)
  ) u_mover (
    .clk(clk), .rst_n(rst_n),
    .any_i(any), .pick_i(pick), .take_o(take),
    .job_src_i(job_src), .job_dst_i(job_dst), .job_cnt_i(job_cnt),
    .job_sz_i(job_sz), .job_sinc_i(job_sinc), .job_dinc_i(job_dinc),
    .fin_o(fin), .fin_ch_o(fin_ch),
    .mrd_req_valid(mrd_req_valid), .mrd_req_ready(mrd_req_ready),
    .mrd_addr(mrd_addr), .mrd_size(mrd_size),
    .mrd_rsp_valid(mrd_rsp_valid), .mrd_rsp_ready(mrd_rsp_ready),
    .mrd_rsp_data(mrd_rsp_data),
    .mwr_valid(mwr_valid), .mwr_ready(mwr_ready),
    .mwr_addr(mwr_addr), .mwr_size(mwr_size), .mwr_data(mwr_data)
  );
endmodule

// File: tb/chan_copy_dma_bench.sv
`timescale 1ns/1ps
module chan_copy_dma_bench;
  localparam int unsigned STAT = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mrd_req_valid, mrd_req_ready = 1'b0;
  logic [63:0] mrd_addr;
  logic [1:0]  mrd_size;
  logic        mrd_rsp_valid = 1'b0, mrd_rsp_ready;
  logic [63:0] mrd_rsp_data = '0;
  logic        mwr_valid, mwr_ready = 1'b0;
  logic [63:0] mwr_addr;
  logic [1:0]  mwr_size;
  logic [63:0] mwr_data;

  chan_copy_dma u_chan_copy_dma (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int r7_err = 0, r8_err = 0, lane_err = 0, rd_hs = 0;
  logic [7:0]  mem [256];
  logic [7:0]  shadow [256];
  logic        bp_en = 1'b0, rd_pend = 1'b0, in_elem = 1'b0, first_seen = 1'b0;
  logic [63:0] rsp_buf = '0, first_rd = '0;
  logic        rd_stall = 1'b0, wr_stall = 1'b0;
  logic [63:0] rd_addr_h = '0, wr_addr_h = '0, wr_data_h = '0;

  typedef struct packed {
    logic [31:0] hi;
    logic [7:0]  src;
    logic [7:0]  dst;
    logic [15:0] cnt;
    logic [1:0]  sz;
    logic        sinc;
    logic        dinc;
    logic [1:0]  ch;
    logic        bp;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0,        8'h10, 8'h80, 16'd8, 2'd0, 1'b1, 1'b1, 2'd0, 1'b0},
    '{32'h0,        8'h20, 8'h90, 16'd4, 2'd2, 1'b1, 1'b1, 2'd1, 1'b1},
    '{32'h0,        8'h40, 8'hA0, 16'd3, 2'd3, 1'b0, 1'b1, 2'd2, 1'b0},
    '{32'h0,        8'h30, 8'hC0, 16'd5, 2'd1, 1'b1, 1'b0, 2'd3, 1'b1},
    '{32'h12345678, 8'h50, 8'hE0, 16'd2, 2'd3, 1'b1, 1'b1, 2'd1, 1'b1},
    '{32'h0,        8'hF0, 8'hF2, 16'd6, 2'd0, 1'b1, 1'b1, 2'd0, 1'b0}
  };

  // memory responder: decides ready and commits handshakes on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      mrd_req_ready = 1'b0; mwr_ready = 1'b0; mrd_rsp_valid = 1'b0;
    end else begin
      if (rd_stall && (!mrd_req_valid || mrd_addr != rd_addr_h)) r8_err++;
      if (wr_stall && (!mwr_valid || mwr_addr != wr_addr_h || mwr_data != wr_data_h)) r8_err++;
      mrd_rsp_valid = rd_pend;
      mrd_rsp_data  = rsp_buf;
      rd_pend = 1'b0;
      mrd_req_ready = bp_en ? (cyc % 3 != 0) : 1'b1;
      mwr_ready     = bp_en ? (cyc % 4 != 1) : 1'b1;
      if (mrd_req_valid && mrd_req_ready) begin
        rd_hs++;
        if (in_elem) r7_err++;
        in_elem = 1'b1;
        if (!first_seen) begin first_rd = mrd_addr; first_seen = 1'b1; end
        for (int b = 0; b < 8; b++) rsp_buf[b*8 +: 8] = mem[8'(mrd_addr[7:0] + 8'(b))];
        rd_pend = 1'b1;
      end
      if (mwr_valid && mwr_ready) begin
        if (!in_elem) r7_err++;
        in_elem = 1'b0;
        for (int b = 0; b < 8; b++) begin
          if (b < (1 << mwr_size)) mem[8'(mwr_addr[7:0] + 8'(b))] = mwr_data[b*8 +: 8];
          else if (mwr_data[b*8 +: 8] != 8'h00) lane_err++;
        end
      end
      rd_stall = mrd_req_valid && !mrd_req_ready; rd_addr_h = mrd_addr;
      wr_stall = mwr_valid && !mwr_ready;
      wr_addr_h = mwr_addr; wr_data_h = mwr_data;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 6'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 6'(a);
    #1 d = reg_rdata;
  endtask

  task automatic prog(input int ch, input logic [31:0] hi, input logic [7:0] s,
                      input logic [7:0] dd, input logic [15:0] n);
    reg_wr(ch*8+2, hi);
    reg_wr(ch*8+3, {24'h0, s});
    reg_wr(ch*8+4, hi);
    reg_wr(ch*8+5, {24'h0, dd});
    reg_wr(ch*8+1, {16'hABCD, n});
  endtask

  function automatic logic [31:0] ctl(input logic [1:0] sz, input logic sinc, input logic dinc);
    return 32'h8000_0000 | (32'(sz) << 25) | (32'(dinc) << 24) | (32'(sinc) << 23);
  endfunction

  task automatic wait_bit(input int ch, output logic [31:0] st);
    for (int i = 0; i < 3000; i++) begin
      reg_rd(STAT, st);
      if (st[ch]) break;
    end
  endtask

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, st;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 37 + 11);
      shadow[i] = mem[i];
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    reg_rd(0, d);  check(d == 0, "R1 ctrl ch0", 64'(d), 0);
    reg_rd(25, d); check(d == 0, "R1 count ch3", 64'(d), 0);
    reg_rd(23, d); check(d == 0, "R1 desc lo ch2", 64'(d), 0);
    reg_rd(STAT, d); check(d == 0, "R1 status", 64'(d), 0);

    // R2: register map readback
    reg_wr(22, 32'hCAFE_0001); reg_wr(23, 32'h0BAD_F00D); reg_wr(17, 32'h0000_0000);
    reg_wr(16, 32'h0180_0000);
    reg_rd(22, d); check(d == 32'hCAFE_0001, "R2 desc hi ch2", 64'(d), 64'h CAFE_0001);
    reg_rd(23, d); check(d == 32'h0BAD_F00D, "R2 desc lo ch2", 64'(d), 64'h0BAD_F00D);
    reg_rd(16, d); check(d == 32'h0180_0000, "R2 ctrl ch2 no enable", 64'(d), 64'h0180_0000);

    // R3: halves independent
    reg_wr(10, 32'h1111_2222); reg_wr(11, 32'h3333_4444); reg_wr(10, 32'h5555_6666);
    reg_rd(11, d); check(d == 32'h3333_4444, "R3 low kept", 64'(d), 64'h3333_4444);
    reg_rd(10, d); check(d == 32'h5555_6666, "R3 high new", 64'(d), 64'h5555_6666);

    // R12: unimplemented offsets
    reg_wr(34, 32'hFFFF_FFFF);
    reg_rd(33, d); check(d == 0, "R12 read 0x21", 64'(d), 0);
    reg_rd(34, d); check(d == 0, "R12 read 0x22 after write", 64'(d), 0);
    reg_rd(STAT, d); check(d == 0, "R12 status untouched", 64'(d), 0);

    // R4: zero low count starts nothing
    reg_wr(25, 32'h0001_0000);
    reg_wr(24, ctl(2'd0, 1'b1, 1'b1));
    repeat (30) @(negedge clk);
    check(rd_hs == 0, "R4 no read for zero count", 64'(rd_hs), 0);
    reg_rd(STAT, d); check(d == 0, "R4 no completion for zero count", 64'(d), 0);

    // vector table: R2 R5 R6 R9
    for (int v = 0; v < NVEC; v++) begin
      vec_t t;
      logic [7:0] tmp [8];
      bit same;
      int w, sa, da;
      t = VECS[v];
      w = 1 << t.sz;
      for (int i = 0; i < int'(t.cnt); i++) begin
        sa = int'(t.src) + (t.sinc ? i * w : 0);
        da = int'(t.dst) + (t.dinc ? i * w : 0);
        for (int b = 0; b < w; b++) tmp[b] = shadow[(sa + b) & 255];
        for (int b = 0; b < w; b++) shadow[(da + b) & 255] = tmp[b];
      end
      prog(int'(t.ch), t.hi, t.src, t.dst, t.cnt);
      bp_en = t.bp;
      first_seen = 1'b0;
      reg_wr(int'(t.ch) * 8, ctl(t.sz, t.sinc, t.dinc));
      wait_bit(int'(t.ch), st);
      check(st[t.ch] == 1'b1, "R9 completion bit", 64'(st), 64'(1 << t.ch));
      same = 1'b1;
      for (int i = 0; i < 256; i++) if (mem[i] != shadow[i]) same = 1'b0;
      check(same, "R5 R6 memory image after copy", 64'(v), 64'(v));
      check(first_rd == {t.hi, 24'h0, t.src}, "R2 first read address", first_rd, {t.hi, 24'h0, t.src});
      reg_rd(int'(t.ch) * 8, d);
      check(d == (ctl(t.sz, t.sinc, t.dinc) & 32'h7FFF_FFFF), "R9 enable cleared", 64'(d),
            64'(ctl(t.sz, t.sinc, t.dinc) & 32'h7FFF_FFFF));
      reg_wr(STAT, 32'(1 << t.ch));
    end
    bp_en = 1'b0;

    // R11: queued channels served lowest first
    begin
      int t0, t1, t2;
      t0 = -1; t1 = -1; t2 = -1;
      prog(0, 32'h0, 8'h00, 8'h60, 16'd40);
      prog(1, 32'h0, 8'h00, 8'h70, 16'd2);
      prog(2, 32'h0, 8'h00, 8'h78, 16'd2);
      reg_wr(0, ctl(2'd0, 1'b1, 1'b1));
      reg_wr(16, ctl(2'd0, 1'b1, 1'b1));
      reg_wr(8, ctl(2'd0, 1'b1, 1'b1));
      for (int i = 0; i < 3000; i++) begin
        reg_rd(STAT, st);
        if (st[0] && t0 < 0) t0 = i;
        if (st[1] && t1 < 0) t1 = i;
        if (st[2] && t2 < 0) t2 = i;
        if (st[2:0] == 3'b111) break;
      end
      check(t0 >= 0 && t1 > t0, "R11 ch1 after running ch0", 64'(t1), 64'(t0 + 1));
      check(t2 > t1, "R11 ch1 before ch2", 64'(t2), 64'(t1 + 1));
    end

    // R10: write-one-to-clear
    reg_wr(STAT, 32'h5);
    reg_rd(STAT, d); check(d == 32'h2, "R10 partial clear", 64'(d), 64'h2);
    reg_wr(STAT, 32'h2);
    reg_rd(STAT, d); check(d == 32'h0, "R10 full clear", 64'(d), 64'h0);

    check(r7_err == 0, "R7 read-write ordering", 64'(r7_err), 0);
    check(r8_err == 0, "R8 request held under back-pressure", 64'(r8_err), 0);
    check(lane_err == 0, "R5 upper lanes zero", 64'(lane_err), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule